// File: doc/BRIEF.md
# Serial Frame Alignment and Quality Tracker

This block sits on a serial 810-byte frame stream, one bit per clock, most significant bit of each byte first. It looks for the two-byte framing word 0xF6, 0x28 that opens every frame. Once it has found the word, it keeps a bit counter and a byte counter in step with the frame. Downstream logic uses the reported bit and byte position to pick out overhead and payload bytes, without having to search for the frame itself.

Frame quality is judged once per frame, at the position where the framing word must end. A run of missed framing words moves the tracker through progressively worse conditions: errored, severely errored and finally out of frame. Two good framing words in a row bring it back to in-frame. While it is out of frame and has no candidate alignment, it hunts at every bit position. The first hit realigns the counters, and a second hit one frame later confirms the lock.

Top module: `sts1_frame_align`

## Requirements
- R1: A framing word is present when the last 16 received bits, taking the bit on `ser_in` in the current cycle as the newest and the oldest bit as the most significant, equal 0xF6 followed by 0x28 (0xF628). Any other value is a missed framing word.
- R2: `bit_pos` advances by one every cycle from 0 to 7 and wraps from 7 to 0.
- R3: `byte_pos` advances by one in each cycle in which `bit_pos` wraps, runs from 0 to FRAME_BYTES-1 (810 by default) and then wraps to 0.
- R4: While hunting (out of frame with no pending candidate), a framing word at any bit position realigns the counters. In the next cycle `bit_pos` is 0 and `byte_pos` is 2, and this hit counts as the first good framing word.
- R5: When not hunting, the framing word is judged only in the cycle with `byte_pos` = 1 and `bit_pos` = 7. A framing word anywhere else leaves the counters and the state untouched.
- R6: After reset the tracker is out of frame with `frame_state` = 3, only `out_of_frame` high, and both positions 0.
- R7: Two consecutive good framing words move the tracker to in-frame. The state change shows in the cycle after the judging cycle.
- R8: A good framing word clears the count of consecutive misses, and a miss increments it, saturating at 24. Outside out-of-frame, a count of at least 2 gives errored frame, at least 4 gives severely errored frame, and 24 gives out of frame. Misses never move the tracker to a milder state than the one it holds.
- R9: Out of frame with one good framing word pending, a miss at the judged position cancels the candidate and returns the tracker to hunting.
- R10: Exactly one of `in_frame`, `err_frame`, `sev_err_frame`, `out_of_frame` is high at any time. `frame_state` encodes the state as 0 in-frame, 1 errored, 2 severely errored, 3 out of frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_in | input | 1 | Received serial data, one bit per clock |
| in_frame | output | 1 | High while in-frame |
| err_frame | output | 1 | High while in the errored-frame state |
| sev_err_frame | output | 1 | High while in the severely-errored-frame state |
| out_of_frame | output | 1 | High while out of frame |
| frame_state | output | 2 | State code: 0 in-frame, 1 errored, 2 severely errored, 3 out of frame |
| bit_pos | output | 3 | Bit index within the current byte |
| byte_pos | output | 10 | Byte index within the current frame |

## Verification
The last bit of the framing word is judged in the cycle it sits on `ser_in`. The state flags and the realigned positions appear one clock later. The bench therefore drives bits on falling edges and samples the outputs at the falling edge right after the last framing bit has been clocked in, and again at the falling edge where each frame should start at position 0/0. Expected states come from a frame-level model in the bench, applied once per sent frame. The bench shortens the frame through the FRAME_BYTES parameter so that long miss runs fit in a short run.

// File: rtl/sts1_align_pkg.sv
// Shared types for the serial frame alignment tracker.
// The state encoding doubles as a severity order: a larger code is a worse
// condition, which the quality FSM relies on when it compares states.
package sts1_align_pkg;

    typedef enum logic [1:0] {
        ST_IN  = 2'd0,
        ST_EF  = 2'd1,
        ST_SEF = 2'd2,
        ST_OOF = 2'd3
    } align_state_e;

    localparam int NUM_STATES = 4;

endpackage

// File: rtl/sts1_pattern_window.sv
// Sliding window over the serial input.
// Keeps the previous PAT_W-1 bits and appends the live input bit, so a match
// is flagged in the same cycle the final pattern bit is on ser_in.
// Assumes the oldest bit is the most significant bit of PATTERN.
module sts1_pattern_window #(
    parameter int               PAT_W   = 16,
    parameter logic [PAT_W-1:0] PATTERN = 16'hF628
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_in,
    output logic match
);

    logic [PAT_W-2:0] hist_q;
    logic [PAT_W-1:0] window;

    // Shift history: the newest bit enters at the least significant end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= window[PAT_W-2:0];
        end
    end

    // Window comparison, including the bit that is live this cycle.
    always_comb begin
        window = {hist_q, ser_in};
        match  = (window == PATTERN);
    end

    // R1: a match requires the previous newest bit to equal pattern bit 1.
    a_r1_history_consistent: assert property (@(posedge clk) disable iff (!rst_n)
        (match && $past(rst_n)) |-> ($past(ser_in) == PATTERN[1]));

endmodule

// File: rtl/sts1_position_counter.sv
// Bit and byte position counters for one frame.
// A realign request forces the position just after the framing word.
// Otherwise the counters free-run. at_check marks the cycle in which the
// last framing bit is expected on the input.
// Assumes RESUME_BYTE >= 1 and RESUME_BYTE < BYTES.
module sts1_position_counter #(
    parameter int BITS        = 8,
    parameter int BYTES       = 810,
    parameter int RESUME_BYTE = 2,
    parameter int BIT_W       = $clog2(BITS),
    parameter int BYTE_W      = $clog2(BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              realign,
    output logic [BIT_W-1:0]  bit_pos,
    output logic [BYTE_W-1:0] byte_pos,
    output logic              at_check
);

    localparam logic [BIT_W-1:0]  BIT_LAST   = BIT_W'(BITS - 1);
    localparam logic [BYTE_W-1:0] BYTE_LAST  = BYTE_W'(BYTES - 1);
    localparam logic [BYTE_W-1:0] BYTE_RESUM = BYTE_W'(RESUME_BYTE);
    localparam logic [BYTE_W-1:0] BYTE_CHECK = BYTE_W'(RESUME_BYTE - 1);

    logic [BIT_W-1:0]  bit_q;
    logic [BYTE_W-1:0] byte_q;

    // Advance, wrap or realign the two counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q  <= '0;
            byte_q <= '0;
        end else if (realign) begin
            bit_q  <= '0;
            byte_q <= BYTE_RESUM;
        end else if (bit_q == BIT_LAST) begin
            bit_q  <= '0;
            byte_q <= (byte_q == BYTE_LAST) ? '0 : byte_q + 1'b1;
        end else begin
            bit_q  <= bit_q + 1'b1;
        end
    end

    // Expose positions and flag the judging instant.
    always_comb begin
        bit_pos  = bit_q;
        byte_pos = byte_q;
        at_check = (byte_q == BYTE_CHECK) && (bit_q == BIT_LAST);
    end

    // R2: the bit counter wraps to zero after its last value.
    a_r2_bit_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_q == BIT_LAST && !realign) |=> (bit_q == '0));

    // R3: the byte counter stays within the frame.
    a_r3_byte_bound: assert property (@(posedge clk) disable iff (!rst_n)
        byte_q <= BYTE_LAST);

    // R3: the byte counter only moves on a bit wrap or a realign.
    a_r3_byte_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_q != BIT_LAST && !realign) |=> $stable(byte_q));

    // R4: a realign lands on the position after the framing word.
    a_r4_realign_target: assert property (@(posedge clk) disable iff (!rst_n)
        realign |=> (bit_q == '0 && byte_q == BYTE_RESUM));

endmodule

// File: rtl/sts1_quality_fsm.sv
// Frame quality state machine.
// Counts consecutive good and missed framing words and moves between the
// in-frame, errored, severely errored and out-of-frame states. While out of
// frame with no candidate it hunts: any match is taken as a candidate.
// Otherwise the word is judged only when at_check is high.
// Assumes 1 <= EF_LIMIT <= SEF_LIMIT <= OOF_LIMIT and LOCK_COUNT >= 1.
module sts1_quality_fsm
    import sts1_align_pkg::*;
#(
    parameter int EF_LIMIT   = 2,
    parameter int SEF_LIMIT  = 4,
    parameter int OOF_LIMIT  = 24,
    parameter int LOCK_COUNT = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         match,
    input  logic         at_check,
    output align_state_e state,
    output logic         hunting
);

    localparam int ERR_W  = $clog2(OOF_LIMIT + 1);
    localparam int GOOD_W = $clog2(LOCK_COUNT + 1);
    localparam logic [ERR_W-1:0]  ERR_OOF  = ERR_W'(OOF_LIMIT);
    localparam logic [ERR_W-1:0]  ERR_SEF  = ERR_W'(SEF_LIMIT);
    localparam logic [ERR_W-1:0]  ERR_EF   = ERR_W'(EF_LIMIT);
    localparam logic [GOOD_W-1:0] GOOD_MAX = GOOD_W'(LOCK_COUNT);
    localparam logic [GOOD_W-1:0] GOOD_ONE = GOOD_W'(1);

    align_state_e      state_q;
    align_state_e      miss_level;
    logic [ERR_W-1:0]  err_q;
    logic [ERR_W-1:0]  err_next;
    logic [GOOD_W-1:0] good_q;
    logic [GOOD_W-1:0] good_next;

    // Saturating next counts and the severity implied by one more miss.
    always_comb begin
        err_next  = (err_q == ERR_OOF) ? err_q : err_q + 1'b1;
        good_next = (good_q == GOOD_MAX) ? good_q : good_q + 1'b1;
        if (err_next >= ERR_OOF) begin
            miss_level = ST_OOF;
        end else if (err_next >= ERR_SEF) begin
            miss_level = ST_SEF;
        end else if (err_next >= ERR_EF) begin
            miss_level = ST_EF;
        end else begin
            miss_level = ST_IN;
        end
        hunting = (state_q == ST_OOF) && (good_q == '0);
        state   = state_q;
    end

    // State and run-length counters, updated on hunt hits and judged words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OOF;
            err_q   <= '0;
            good_q  <= '0;
        end else if (hunting) begin
            if (match) begin
                err_q  <= '0;
                good_q <= GOOD_ONE;
                if (GOOD_ONE >= GOOD_MAX) begin
                    state_q <= ST_IN;
                end
            end
        end else if (at_check) begin
            if (match) begin
                err_q  <= '0;
                good_q <= good_next;
                if (good_next >= GOOD_MAX) begin
                    state_q <= ST_IN;
                end
            end else begin
                err_q  <= err_next;
                good_q <= '0;
                if (state_q != ST_OOF && miss_level > state_q) begin
                    state_q <= miss_level;
                end
            end
        end
    end

    // R8: the miss count never passes its ceiling.
    a_r8_err_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        err_q <= ERR_OOF);

    // R7: in-frame is only entered on a matching framing word.
    a_r7_lock_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IN && $past(state_q) != ST_IN) |-> $past(match));

    // R8: a worse state is only reached through a judged miss.
    a_r8_worse_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q > $past(state_q)) |-> $past(at_check && !match && !hunting));

    // R9: a miss against a pending candidate resumes the hunt.
    a_r9_miss_rehunts: assert property (@(posedge clk) disable iff (!rst_n)
        (!hunting && state_q == ST_OOF && at_check && !match) |=> hunting);

    // R4: a hit while hunting ends the hunt.
    a_r4_hunt_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (hunting && match) |=> !hunting);

endmodule

// File: rtl/sts1_frame_align.sv
// Top level of the serial frame alignment tracker.
// Joins the pattern window, the position counters and the quality FSM,
// and decodes the state into one flag per state.
// Assumes a continuous serial stream, one bit per clk, MSB of each byte first.
module sts1_frame_align
    import sts1_align_pkg::*;
#(
    parameter int                       BITS_PER_BYTE = 8,
    parameter int                       FRAME_BYTES   = 810,
    parameter logic [BITS_PER_BYTE-1:0] SYNC_HI       = 8'hF6,
    parameter logic [BITS_PER_BYTE-1:0] SYNC_LO       = 8'h28,
    parameter int                       EF_LIMIT      = 2,
    parameter int                       SEF_LIMIT     = 4,
    parameter int                       OOF_LIMIT     = 24,
    parameter int                       LOCK_COUNT    = 2,
    parameter int                       BIT_W         = $clog2(BITS_PER_BYTE),
    parameter int                       BYTE_W        = $clog2(FRAME_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    output logic              in_frame,
    output logic              err_frame,
    output logic              sev_err_frame,
    output logic              out_of_frame,
    output logic [1:0]        frame_state,
    output logic [BIT_W-1:0]  bit_pos,
    output logic [BYTE_W-1:0] byte_pos
);

    localparam int PAT_W = 2 * BITS_PER_BYTE;
    localparam logic [PAT_W-1:0] SYNC_WORD = {SYNC_HI, SYNC_LO};

    logic                  match;
    logic                  at_check;
    logic                  hunting;
    logic                  realign;
    align_state_e          state;
    logic [NUM_STATES-1:0] flag_vec;

    sts1_pattern_window #(
        .PAT_W   (PAT_W),
        .PATTERN (SYNC_WORD)
    ) u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .ser_in (ser_in),
        .match  (match)
    );

    sts1_position_counter #(
        .BITS        (BITS_PER_BYTE),
        .BYTES       (FRAME_BYTES),
        .RESUME_BYTE (2),
        .BIT_W       (BIT_W),
        .BYTE_W      (BYTE_W)
    ) u_position (
        .clk      (clk),
        .rst_n    (rst_n),
        .realign  (realign),
        .bit_pos  (bit_pos),
        .byte_pos (byte_pos),
        .at_check (at_check)
    );

    sts1_quality_fsm #(
        .EF_LIMIT   (EF_LIMIT),
        .SEF_LIMIT  (SEF_LIMIT),
        .OOF_LIMIT  (OOF_LIMIT),
        .LOCK_COUNT (LOCK_COUNT)
    ) u_quality (
        .clk      (clk),
        .rst_n    (rst_n),
        .match    (match),
        .at_check (at_check),
        .state    (state),
        .hunting  (hunting)
    );

    // Counters are only pulled into line by a hit found while hunting.
    assign realign = hunting && match;

    // One flag per state code.
    for (genvar s = 0; s < NUM_STATES; s++) begin : g_flag
        assign flag_vec[s] = (state == align_state_e'(s));
    end

    assign in_frame      = flag_vec[ST_IN];
    assign err_frame     = flag_vec[ST_EF];
    assign sev_err_frame = flag_vec[ST_SEF];
    assign out_of_frame  = flag_vec[ST_OOF];
    assign frame_state   = state;

    // R10: the four status flags are mutually exclusive and never all low.
    a_r10_single_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({out_of_frame, sev_err_frame, err_frame, in_frame}));

    // R5: when aligned, the positions change only by a plain count step.
    a_r5_no_jump_when_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (!hunting && bit_pos != BIT_W'(BITS_PER_BYTE - 1)) |=> (bit_pos == $past(bit_pos) + 1'b1));

endmodule

// File: tb/sts1_frame_align_test.sv
// Bench for the frame alignment tracker with a shortened frame.
module sts1_frame_align_test;

    localparam int FB = 24;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ser_in;
    logic       in_frame, err_frame, sev_err_frame, out_of_frame;
    logic [1:0] frame_state;
    logic [2:0] bit_pos;
    logic [4:0] byte_pos;

    int  n_run   = 0;
    int  n_fail  = 0;
    int  m_state = 3;
    int  m_err   = 0;
    int  m_good  = 0;
    bit  aligned = 1'b0;
    bit  done    = 1'b0;

    always #10 clk = ~clk;

    sts1_frame_align #(.FRAME_BYTES(FB)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ser_in        (ser_in),
        .in_frame      (in_frame),
        .err_frame     (err_frame),
        .sev_err_frame (sev_err_frame),
        .out_of_frame  (out_of_frame),
        .frame_state   (frame_state),
        .bit_pos       (bit_pos),
        .byte_pos      (byte_pos)
    );

    task automatic chk(string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic int level_of(int e);
        if (e >= 24) return 3;
        if (e >= 4)  return 2;
        if (e >= 2)  return 1;
        return 0;
    endfunction

    // Frame-level reference model, one step per sent framing word.
    task automatic model_frame(bit valid, bit hunting);
        if (hunting) begin
            if (valid) begin
                m_good = 1;
                m_err  = 0;
            end
        end else if (valid) begin
            m_err = 0;
            if (m_good < 2) m_good++;
            if (m_good >= 2) m_state = 0;
        end else begin
            m_good = 0;
            if (m_err < 24) m_err++;
            if (m_state != 3 && level_of(m_err) > m_state) m_state = level_of(m_err);
        end
    endtask

    // Filler bytes never contain two adjacent ones, so no false framing word.
    function automatic logic [7:0] fill_byte();
        case ($urandom % 6)
            0: return 8'h00;
            1: return 8'h55;
            2: return 8'h11;
            3: return 8'h44;
            4: return 8'h22;
            default: return 8'h05;
        endcase
    endfunction

    task automatic send_bit(logic b);
        ser_in = b;
        @(negedge clk);
    endtask

    task automatic send_byte(logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic send_frame(bit valid, bit stray, string tag);
        bit          hunting;
        logic [15:0] pat;
        hunting = (m_state == 3 && m_good == 0);
        if (aligned) begin
            chk({tag, " R3 byte_pos at frame start"}, byte_pos, 0);
            chk({tag, " R2 bit_pos at frame start"}, bit_pos, 0);
        end
        pat = 16'hF628;
        if (!valid) pat = pat ^ (16'd1 << ($urandom % 16));
        for (int i = 15; i >= 0; i--) send_bit(pat[i]);
        model_frame(valid, hunting);
        if (hunting && valid) aligned = 1'b1;
        chk({tag, " frame_state"}, frame_state, m_state);
        chk({tag, " R10 flags"}, {out_of_frame, sev_err_frame, err_frame, in_frame}, 1 << m_state);
        if (aligned) begin
            chk({tag, " R4 byte_pos after word"}, byte_pos, 2);
            chk({tag, " R4 bit_pos after word"}, bit_pos, 0);
        end
        for (int b = 2; b < FB; b++) begin
            if (stray && b == 10)      send_byte(8'hF6);
            else if (stray && b == 11) send_byte(8'h28);
            else                       send_byte(fill_byte());
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        void'($urandom(32'd4711));
        rst_n  = 1'b0;
        ser_in = 1'b0;
        repeat (3) @(negedge clk);
        chk("R6 reset flags", {out_of_frame, sev_err_frame, err_frame, in_frame}, 8);
        chk("R6 reset frame_state", frame_state, 3);
        chk("R6 reset bit_pos", bit_pos, 0);
        chk("R6 reset byte_pos", byte_pos, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) send_byte(fill_byte());
        repeat (3) send_bit(1'b0);

        send_frame(1, 0, "R4 first word while hunting");
        send_frame(1, 0, "R7 second good word");
        send_frame(1, 1, "R5 stray word in payload");
        chk("R5 counters unmoved by stray word", byte_pos, 0);
        send_frame(0, 0, "R1 corrupted word is a miss");
        send_frame(1, 0, "R8 good word clears misses");
        send_frame(0, 0, "R8 miss one");
        send_frame(0, 0, "R8 miss two errored");
        send_frame(0, 0, "R8 miss three");
        send_frame(0, 0, "R8 miss four severe");
        send_frame(1, 0, "R8 one good keeps severe");
        send_frame(0, 0, "R8 no demotion miss one");
        send_frame(0, 0, "R8 no demotion miss two");
        send_frame(1, 0, "R7 recover one");
        send_frame(1, 0, "R7 recover two");
        for (int k = 0; k < 24; k++) send_frame(0, 0, "R8 miss run");
        chk("R8 out of frame after 24 misses", out_of_frame, 1);

        // Shift the phase while hunting.
        repeat (3) send_bit(1'b0);
        aligned = 1'b0;
        send_frame(1, 0, "R4 new phase hit");
        send_frame(0, 0, "R9 miss cancels candidate");
        send_frame(0, 0, "R9 miss while hunting");
        send_frame(1, 0, "R4 hunt hit again");
        send_frame(1, 0, "R7 relock");

        for (int k = 0; k < 30; k++) begin
            send_frame(($urandom % 10) < 7, 0, "R8 random");
        end

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R7: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule